// File: doc/BRIEF.md
# Linked-Segment Payload String Matcher

The block scans a packet payload one byte per cycle and reports string patterns that were compiled ahead of time into chains of fixed-length segments. A running hash of the most recent segment-length bytes addresses a segment table. A lookup counts as a hit only when the stored bytes equal the window exactly. A hit on a chain head either raises an alert at once, for a one-segment pattern, or arms a single pending chain. The pending chain expects the linked segment to end exactly one segment length later. No payload is buffered beyond the window itself.

Each table entry holds the segment bytes, a head flag, a last flag, a link to the next segment, one sibling link, and a pattern id. Two patterns that begin with the same segment store it once. They diverge through the sibling link of the first continuation entry. A completed pattern raises an alert only if the header-lookup rule vector has the pattern's bit set. Host software fills the table through a write port before traffic starts.

Top module: `smatch_top`

## Requirements
- R1: After reset, alert_valid is 0 and every table entry is invalid, so no byte stream produces an alert until entries are written.
- R2: A cycle with cfg_we high writes the entry at cfg_addr, and the next cycle already uses it. cfg_seg holds segment byte i (i = 0 is the earliest byte in the stream) at bits [8*i+7:8*i]. Writing cfg_valid = 0 removes the entry.
- R3: The lookup address is the XOR over i = 0..4 of the 9-bit value {1'b0, byte i} rotated left by i, taken over the window that includes the current byte. A head hit needs a valid entry with the head flag set, all 5 stored bytes equal to the window, and at least 5 bytes received since start of packet.
- R4: An alert is a one-cycle pulse on alert_valid in the clock cycle after the byte that completes the pattern, with alert_pid equal to the id of the entry that completed it.
- R5: After a segment hit that is not last, the segment at the link address must match the window whose final byte arrives exactly 5 bytes later. Any other gap or content drops the chain.
- R6: At that check byte, the entry at the link address's sibling address (when the sibling enable is set) is also a candidate. The primary entry wins when both match. This lets one stored leading segment serve two patterns.
- R7: A completed pattern raises alert_valid only if rule_vec[pid] is 1 in the cycle its final byte is accepted.
- R8: in_sop marks the first byte of a packet and restarts the window and the chain state with that byte. in_eop marks the last byte, which is still matched, and drops any pending chain after it.
- R9: Only one chain is tracked. Head hits are ignored while a chain waits for its check byte. On the check byte, if the chain completes or fails, a head hit in the same cycle starts a new chain or raises its own alert; a chain completion takes the alert output before a head alert.
- R10: A window whose hash equals a stored head's address but whose bytes differ produces no hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | 9 | Table entry address |
| cfg_valid | input | 1 | Entry valid bit written |
| cfg_seg | input | 40 | Segment bytes, byte i at bits [8*i+7:8*i] |
| cfg_head | input | 1 | Entry may start a chain via hash lookup |
| cfg_last | input | 1 | Entry completes its pattern |
| cfg_alt_en | input | 1 | Sibling candidate enable |
| cfg_alt | input | 9 | Sibling entry address |
| cfg_next | input | 9 | Next segment address |
| cfg_pid | input | 4 | Pattern id |
| in_valid | input | 1 | Payload byte present |
| in_sop | input | 1 | Byte is first of packet |
| in_eop | input | 1 | Byte is last of packet |
| in_byte | input | 8 | Payload byte |
| rule_vec | input | 16 | Header-lookup result, one bit per pattern id |
| alert_valid | output | 1 | One-cycle alert pulse |
| alert_pid | output | 4 | Pattern id of the alert |

## Verification
Two events can land on the same byte: a chain's check-byte completion and a fresh head hit. The bench provokes this with a stream in which one pattern's final segment is also the head of a second pattern. It expects an alert for the first pattern on that byte and an alert for the second exactly five bytes later. A head hit that falls while a chain is still counting toward its check byte is also provoked, inside the same first pattern, and is judged by the absence of that head's own alert. A separate stream shows that the same head alerts when no chain is pending.

// File: rtl/smatch_pkg.sv
package smatch_pkg;
    localparam int SEG_LEN = 5;
    localparam int ADDR_W  = 9;
    localparam int PID_W   = 4;
    localparam int SEG_W   = SEG_LEN * 8;
    localparam int RULE_N  = 1 << PID_W;
    localparam int DEPTH   = 1 << ADDR_W;
    localparam int CNT_W   = $clog2(SEG_LEN + 1);

    typedef struct packed {
        logic              vld;
        logic [SEG_W-1:0]  seg;
        logic              head;
        logic              last;
        logic              alt_en;
        logic [ADDR_W-1:0] alt;
        logic [ADDR_W-1:0] nxt;
        logic [PID_W-1:0]  pid;
    } seg_entry_t;

    // Byte i (0 = earliest) is widened and rotated left by i, then all are XORed.
    function automatic logic [ADDR_W-1:0] seg_hash(input logic [SEG_W-1:0] w);
        logic [ADDR_W-1:0] acc;
        logic [ADDR_W-1:0] x;
        int r;
        acc = '0;
        for (int i = 0; i < SEG_LEN; i++) begin
            x   = ADDR_W'(w[8*i +: 8]);
            r   = i % ADDR_W;
            acc = acc ^ ((x << r) | (x >> (ADDR_W - r)));
        end
        return acc;
    endfunction
endpackage

// File: rtl/smatch_window.sv
module smatch_window
    import smatch_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc,
    input  logic             sop,
    input  logic [7:0]       byte_i,
    output logic [SEG_W-1:0] win_now,
    output logic             full_now
);
    typedef struct packed {
        logic [SEG_W-1:0] win;
        logic [CNT_W-1:0] fill;
    } win_st_t;

    win_st_t          st_d, st_q;
    logic [CNT_W-1:0] fill_now;

    always_comb begin
        // newest byte enters at the top; byte 0 of the window is the oldest
        if (sop) begin
            win_now  = {byte_i, {(SEG_W-8){1'b0}}};
            fill_now = CNT_W'(1);
        end else begin
            win_now  = {byte_i, st_q.win[SEG_W-1:8]};
            fill_now = (st_q.fill == CNT_W'(SEG_LEN)) ? st_q.fill : st_q.fill + 1'b1;
        end
        full_now = (fill_now == CNT_W'(SEG_LEN));
        st_d = st_q;
        if (acc) begin
            st_d.win  = win_now;
            st_d.fill = fill_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8: a start-of-packet byte leaves exactly one byte in the window
    a_r8_window_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && sop) |=> (st_q.fill == CNT_W'(1)));
endmodule

// File: rtl/smatch_table.sv
module smatch_table
    import smatch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  seg_entry_t        cfg_entry,
    input  logic [ADDR_W-1:0] hash_addr,
    input  logic [ADDR_W-1:0] link_addr,
    output seg_entry_t        e_hash,
    output seg_entry_t        e_link,
    output seg_entry_t        e_alt
);
    logic [DEPTH-1:0] vld_d, vld_q;
    seg_entry_t       mem [DEPTH];
    logic [ADDR_W-1:0] alt_addr;

    always_comb begin
        vld_d = vld_q;
        if (cfg_we) vld_d[cfg_addr] = cfg_entry.vld;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= vld_d;
    end

    always_ff @(posedge clk) begin
        if (cfg_we) mem[cfg_addr] <= cfg_entry;
    end

    always_comb begin
        e_hash     = mem[hash_addr];
        e_hash.vld = vld_q[hash_addr];
        e_link     = mem[link_addr];
        e_link.vld = vld_q[link_addr];
        alt_addr   = e_link.alt;
        e_alt      = mem[alt_addr];
        e_alt.vld  = vld_q[alt_addr];
    end

    // R2: a written valid bit is in force on the next cycle
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (vld_q[$past(cfg_addr)] == $past(cfg_entry.vld)));
endmodule

// File: rtl/smatch_chain.sv
module smatch_chain
    import smatch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic              sop,
    input  logic              eop,
    input  logic [SEG_W-1:0]  win_now,
    input  logic              full_now,
    input  seg_entry_t        e_hash,
    input  seg_entry_t        e_link,
    input  seg_entry_t        e_alt,
    input  logic [RULE_N-1:0] rule_vec,
    output logic [ADDR_W-1:0] link_addr,
    output logic              alert_valid,
    output logic [PID_W-1:0]  alert_pid
);
    localparam logic [CNT_W-1:0] GAP = CNT_W'(SEG_LEN - 1);

    typedef struct packed {
        logic              pend;
        logic [ADDR_W-1:0] expa;
        logic [CNT_W-1:0]  cnt;
        logic              av;
        logic [PID_W-1:0]  apid;
    } chain_st_t;

    chain_st_t  st_d, st_q;
    logic       live, at_chk, hit_p, hit_a, step_ok, head_hit, busy, done;
    seg_entry_t pick;
    logic       unused_fields;

    assign unused_fields = ^{e_hash, e_link, e_alt, pick};

    always_comb begin
        live     = st_q.pend && !sop;
        at_chk   = live && (st_q.cnt == '0);
        hit_p    = e_link.vld && (e_link.seg == win_now);
        hit_a    = e_link.vld && e_link.alt_en && e_alt.vld && (e_alt.seg == win_now);
        pick     = hit_p ? e_link : e_alt;
        step_ok  = at_chk && (hit_p || hit_a);
        head_hit = full_now && e_hash.vld && e_hash.head && (e_hash.seg == win_now);
        busy     = 1'b0;
        done     = 1'b0;
        st_d     = st_q;
        st_d.av  = 1'b0;
        if (acc) begin
            st_d.pend = 1'b0;
            if (live && !at_chk) begin
                st_d.pend = 1'b1;
                st_d.cnt  = st_q.cnt - 1'b1;
                busy      = 1'b1;
            end else if (step_ok && !pick.last) begin
                st_d.pend = 1'b1;
                st_d.expa = pick.nxt;
                st_d.cnt  = GAP;
                busy      = 1'b1;
            end else if (step_ok) begin
                st_d.av   = rule_vec[pick.pid];
                st_d.apid = pick.pid;
                done      = 1'b1;
            end
            if (!busy && head_hit) begin
                if (!e_hash.last) begin
                    st_d.pend = 1'b1;
                    st_d.expa = e_hash.nxt;
                    st_d.cnt  = GAP;
                end else if (!done) begin
                    st_d.av   = rule_vec[e_hash.pid];
                    st_d.apid = e_hash.pid;
                end
            end
            if (eop) st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign link_addr   = st_q.expa;
    assign alert_valid = st_q.av;
    assign alert_pid   = st_q.apid;

    // R8: packet edges leave no chain pending
    a_r8_sop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && sop) |=> !st_q.pend);
    a_r8_eop_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && eop) |=> !st_q.pend);
    // R9: a chain short of its check byte keeps its target
    a_r9_chain_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !sop && !eop && st_q.pend && st_q.cnt != '0)
        |=> (st_q.pend && st_q.expa == $past(st_q.expa)));
    // R7: alerts only for enabled rules
    a_r7_rule_gate: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.av |-> (($past(rule_vec) & (RULE_N'(1) << st_q.apid)) != '0));
    // R4: an alert follows an accepted byte
    a_r4_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.av |-> $past(acc));
endmodule

// File: rtl/smatch_top.sv
module smatch_top
    import smatch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_valid,
    input  logic [SEG_W-1:0]  cfg_seg,
    input  logic              cfg_head,
    input  logic              cfg_last,
    input  logic              cfg_alt_en,
    input  logic [ADDR_W-1:0] cfg_alt,
    input  logic [ADDR_W-1:0] cfg_next,
    input  logic [PID_W-1:0]  cfg_pid,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [7:0]        in_byte,
    input  logic [RULE_N-1:0] rule_vec,
    output logic              alert_valid,
    output logic [PID_W-1:0]  alert_pid
);
    logic [SEG_W-1:0]  win_now;
    logic              full_now;
    logic [ADDR_W-1:0] hash_addr, link_addr;
    seg_entry_t        cfg_entry, e_hash, e_link, e_alt;

    always_comb begin
        hash_addr = seg_hash(win_now);
        cfg_entry = '{vld: cfg_valid, seg: cfg_seg, head: cfg_head, last: cfg_last,
                      alt_en: cfg_alt_en, alt: cfg_alt, nxt: cfg_next, pid: cfg_pid};
    end

    smatch_window u_win (
        .clk(clk), .rst_n(rst_n), .acc(in_valid), .sop(in_sop), .byte_i(in_byte),
        .win_now(win_now), .full_now(full_now)
    );

    smatch_table u_tab (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_entry(cfg_entry), .hash_addr(hash_addr), .link_addr(link_addr),
        .e_hash(e_hash), .e_link(e_link), .e_alt(e_alt)
    );

    smatch_chain u_chain (
        .clk(clk), .rst_n(rst_n), .acc(in_valid), .sop(in_sop), .eop(in_eop),
        .win_now(win_now), .full_now(full_now), .e_hash(e_hash), .e_link(e_link),
        .e_alt(e_alt), .rule_vec(rule_vec), .link_addr(link_addr),
        .alert_valid(alert_valid), .alert_pid(alert_pid)
    );

    // R4: no alert in the cycle after an idle cycle
    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !alert_valid);
endmodule

// File: tb/smatch_top_test.sv
module smatch_top_test;
    import smatch_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [ADDR_W-1:0] cfg_addr = '0;
    logic              cfg_valid = 1'b0;
    logic [SEG_W-1:0]  cfg_seg = '0;
    logic              cfg_head = 1'b0, cfg_last = 1'b0, cfg_alt_en = 1'b0;
    logic [ADDR_W-1:0] cfg_alt = '0, cfg_next = '0;
    logic [PID_W-1:0]  cfg_pid = '0;
    logic              in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [7:0]        in_byte = '0;
    logic [RULE_N-1:0] rule_vec = '1;
    logic              alert_valid;
    logic [PID_W-1:0]  alert_pid;

    int n_checks = 0;
    int n_fail = 0;
    int n_al;
    int al_idx [16];
    int al_pid [16];
    bit finished = 1'b0;
    string s;

    always #2 clk = ~clk;

    smatch_top uut (.*);

    function automatic int bhash(input string t);
        int acc = 0;
        for (int i = 0; i < 5; i++) begin
            int x = t[i];
            int v = ((x << i) | (x >> (9 - i))) & 9'h1FF;
            acc = acc ^ v;
        end
        return acc;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int addr, input string seg, input bit vld, input bit head,
                      input bit last, input bit alt_en, input int alt, input int nxt,
                      input int pid);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = ADDR_W'(addr); cfg_valid = vld;
        for (int i = 0; i < 5; i++) cfg_seg[8*i +: 8] = seg[i];
        cfg_head = head; cfg_last = last; cfg_alt_en = alt_en;
        cfg_alt = ADDR_W'(alt); cfg_next = ADDR_W'(nxt); cfg_pid = PID_W'(pid);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(input string t, input bit sop = 1'b1, input bit eop = 1'b1);
        n_al = 0;
        for (int i = 0; i < t.len(); i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sop = sop && (i == 0);
            in_eop = eop && (i == t.len() - 1); in_byte = t[i];
            @(posedge clk); #1;
            if (alert_valid) begin
                if (n_al < 16) begin al_idx[n_al] = i; al_pid[n_al] = int'(alert_pid); end
                n_al++;
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        @(posedge clk); #1;
        chk("R4 alert lasts one cycle", int'(alert_valid), 0);
    endtask

    task automatic expect_one(input string tag, input int idx, input int pid);
        chk({tag, " count"}, n_al, 1);
        chk({tag, " byte index"}, al_idx[0], idx);
        chk({tag, " pid"}, al_pid[0], pid);
    endtask

    initial begin
        #(4 * 60000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int h_bin, h_get, h_kill, h_nk;
        repeat (3) @(posedge clk);
        #1 chk("R1 reset alert low", int'(alert_valid), 0);
        @(negedge clk) rst_n = 1'b1;
        send("GET /");
        chk("R1 empty table no alert", n_al, 0);

        h_bin = bhash("/bin/"); h_get = bhash("GET /");
        h_kill = bhash("kill!"); h_nk = bhash("n/kil");
        wr(h_bin,  "/bin/", 1, 1, 0, 0, 0,     'h1F0, 0);
        wr('h1F0,  "kill!", 1, 0, 1, 1, 'h1F1, 0,     1);
        wr('h1F1,  "chmod", 1, 0, 1, 0, 0,     0,     2);
        wr(h_get,  "GET /", 1, 1, 1, 0, 0,     0,     3);
        wr(h_kill, "kill!", 1, 1, 0, 0, 0,     'h1F2, 0);
        wr('h1F2,  "now!!", 1, 0, 1, 0, 0,     0,     5);
        wr(h_nk,   "n/kil", 1, 1, 1, 0, 0,     0,     6);

        send("GET /");
        expect_one("R3 R4 single segment", 4, 3);
        send("/bin/kill!");
        expect_one("R5 R9 linked pattern, pending ignores head", 9, 1);
        send("/bin/chmod");
        expect_one("R6 sibling segment", 9, 2);
        send("/bin/chmox");
        chk("R6 no candidate matches", n_al, 0);
        send("/bin/Xkill!");
        chk("R5 gap drops chain", n_al, 0);
        send("xn/kil");
        expect_one("R9 head alerts with no chain", 5, 6);

        send("/bin/kill!now!!");
        chk("R9 same-cycle count", n_al, 2);
        chk("R9 first alert index", al_idx[0], 9);
        chk("R9 first alert pid", al_pid[0], 1);
        chk("R9 restarted chain index", al_idx[1], 14);
        chk("R9 restarted chain pid", al_pid[1], 5);

        s = "/bin/kill!";
        s.putc(0, 8'h2E); s.putc(4, 8'h0F);
        chk("R10 alias hash equal", bhash(s), h_bin);
        send(s);
        chk("R10 alias gives no alert", n_al, 0);

        send("/bin/", 1'b1, 1'b1);
        send("kill!", 1'b1, 1'b1);
        chk("R8 eop drops chain", n_al, 0);
        send("/bi", 1'b1, 1'b0);
        send("n/kill!", 1'b1, 1'b1);
        expect_one("R8 sop restarts window", 4, 6);

        rule_vec = '1; rule_vec[1] = 1'b0;
        send("/bin/kill!");
        chk("R7 cleared rule bit blocks alert", n_al, 0);
        for (int p = 0; p < RULE_N; p++) begin
            rule_vec = RULE_N'(1) << p;
            send("GET /");
            chk($sformatf("R7 gate sweep bit %0d", p), n_al, (p == 3) ? 1 : 0);
        end
        rule_vec = '1;

        for (int off = 0; off <= 10; off++) begin
            s = "";
            for (int k = 0; k < off; k++) s = {s, "."};
            s = {s, "GET /"};
            while (s.len() < 16) s = {s, "."};
            send(s);
            expect_one($sformatf("R3 offset %0d", off), off + 4, 3);
        end

        wr(h_get, "GET /", 0, 1, 1, 0, 0, 0, 3);
        send("GET /");
        chk("R2 removed entry silent", n_al, 0);
        wr(h_get, "GET /", 1, 1, 1, 0, 0, 0, 7);
        send("GET /");
        expect_one("R2 rewritten entry", 4, 7);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule